// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

The block is a 16-bit interval timer that decrements once per tick of a selectable count source. When a tick arrives while the count is zero, the counter takes the value held in its reload register and keeps running. In the same cycle it raises a one-cycle interrupt request. With a programmed value n, the timer therefore divides its count source by n+1.

Software-style control comes through plain ports. A start level enables counting. A mode register holds a 2-bit operating field and a 2-bit source field. A value write port loads the timer, and the live count is always visible on an output. The count sources are the clock itself, a divide-by-2 tap, a divide-by-8 tap, a divide-by-32 tap and an externally supplied slow synchronous enable. The clock and the three divided taps all come from one free-running prescaler.

A small state machine controls counting and tells which registers a value write reaches:

- **STOP**: not counting.
- **ARMED**: started, but no tick counted yet.
- **RUN**: at least one tick counted since start.

Its transitions are:

- **STOP→ARMED**: when start is 1 and the operating field is 00.
- **ARMED→RUN**: on the first qualifying tick.
- **ARMED→STOP** and **RUN→STOP**: when start drops or the operating field leaves 00.

In STOP and ARMED a write loads both the counter and the reload register. In RUN a write loads only the reload register, and the counter picks up the new value at its next underflow.

Top module: `ivt_timer`

## Requirements
- R1: After reset the count output is 0x0000, the interrupt output is 0, the mode register is 0000 and the timer is in STOP.
- R2: While counting, each selected tick lowers the count by exactly one, and with programmed value n underflows recur every n+1 ticks.
- R3: A tick at count 0x0000 reloads the counter from the reload register, and the interrupt output is high for exactly the following cycle together with the reloaded count.
- R4: Source field encodings: 00 selects the clock itself (half_sel_i=0) or a tick every 2 clocks (half_sel_i=1). 01 selects a tick every 8 clocks. 10 selects a tick every 32 clocks. 11 selects the slow_tick_i input.
- R5: Counting only happens when the operating field is 00. Any other value holds the count, and returning to 00 with start high resumes counting.
- R6: With start at 0 the count holds its value. A later start continues from the held value rather than reloading.
- R7: A value write in STOP or ARMED loads both counter and reload register, and the count output shows the value in the next cycle. Such a write takes priority over a tick in the same cycle.
- R8: A value write in RUN loads only the reload register. The counter keeps decrementing from its old value and takes the written value at the next underflow.
- R9: Each new start (start rising, or the operating field returning to 00) re-enters ARMED. The first qualifying tick moves the timer to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Count enable level (1 = count) |
| half_sel_i | input | 1 | For source 00: 0 = every clock, 1 = every 2nd clock |
| slow_tick_i | input | 1 | Synchronous single-cycle enable used as source 11 |
| mode_wr_i | input | 1 | Loads the mode register |
| mode_op_i | input | 2 | Operating field; 00 = interval timer |
| mode_src_i | input | 2 | Count-source field |
| val_wr_i | input | 1 | Timer value write strobe |
| val_data_i | input | 16 | Timer value to write |
| count_o | output | 16 | Live count |
| irq_o | output | 1 | One-cycle interrupt request on underflow |

## Verification
The embedded properties check on every cycle the behaviours that hold at any moment:

- a non-zero count drops by one per qualifying tick;
- an interrupt follows a qualifying tick and coincides with a count equal to the reload register;
- the count holds in STOP;
- a RUN write leaves the counter alone and lands in the reload register;
- the first tick in ARMED leads to RUN;
- the prescaler taps nest.

Only the bench scenarios can show the absolute underflow periods for each source encoding, how the write routing changes after a restart, and the effect of a non-zero operating field.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ivt_state_e;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_DIV_A = 2'd1,
        SRC_DIV_B = 2'd2,
        SRC_SLOW  = 2'd3
    } ivt_src_e;

    localparam logic [1:0] OP_TIMER = 2'b00;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_half,
    output logic tick_a,
    output logic tick_b
);
    localparam int PW = $clog2(DIV_B);
    localparam int AW = $clog2(DIV_A);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] taps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // tap g fires once every 2^(g+1) clocks
    for (genvar g = 0; g < PW; g++) begin : g_tap
        assign taps[g] = &pre_q[g:0];
    end

    assign tick_half = taps[0];
    assign tick_a    = taps[AW-1];
    assign tick_b    = taps[PW-1];

    // R4: the slower taps nest inside the faster ones
    p_tap_nesting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b |-> (tick_a && tick_half));

endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
    import ivt_pkg::*;
(
    input  logic [1:0] src,
    input  logic       half_sel,
    input  logic       tick_half,
    input  logic       tick_a,
    input  logic       tick_b,
    input  logic       slow_tick,
    output logic       tick
);
    always_comb begin
        tick = 1'b0;
        unique case (ivt_src_e'(src))
            SRC_FAST:  tick = half_sel ? tick_half : 1'b1;
            SRC_DIV_A: tick = tick_a;
            SRC_DIV_B: tick = tick_b;
            SRC_SLOW:  tick = slow_tick;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt,
    output logic         irq
);
    ivt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d, rld_q, rld_d;
    logic         irq_q, uf;
    logic         live_tick;

    assign live_tick = tick && run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (run) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!run)          state_d = ST_STOP;
                else if (live_tick) state_d = ST_RUN;
            end
            ST_RUN:   if (!run) state_d = ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    // datapath per state
    always_comb begin
        cnt_d = cnt_q;
        rld_d = rld_q;
        uf    = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                if (wr_en) begin
                    cnt_d = wr_data;
                    rld_d = wr_data;
                end
            end
            ST_ARMED: begin
                if (wr_en) begin
                    cnt_d = wr_data;
                    rld_d = wr_data;
                end else if (live_tick) begin
                    if (cnt_q == '0) begin
                        cnt_d = rld_q;
                        uf    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (wr_en) rld_d = wr_data;
                if (live_tick) begin
                    if (cnt_q == '0) begin
                        cnt_d = rld_d;
                        uf    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                cnt_d = cnt_q;
                rld_d = rld_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rld_q <= rld_d;
            irq_q <= uf;
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

    // R3: an interrupt only follows a qualifying tick
    p_irq_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(live_tick));
    // R3: the count after underflow equals the reload register
    p_reload_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == rld_q));
    // R2: a non-zero count drops by one per tick
    p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STOP && live_tick && cnt_q != '0 && !wr_en)
        |=> (cnt_q == W'($past(cnt_q) - 1'b1)));
    // R6: the count holds in STOP
    p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !wr_en) |=> $stable(cnt_q));
    // R8: a RUN write leaves the counter alone
    p_run_write_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wr_en && !live_tick) |=> $stable(cnt_q));
    // R8: a RUN write lands in the reload register
    p_run_write_rld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wr_en) |=> (rld_q == $past(wr_data)));
    // R9: the first tick in ARMED leads to RUN
    p_first_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && live_tick) |=> (state_q == ST_RUN));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_A = 8,
    parameter int DIV_B = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             half_sel_i,
    input  logic             slow_tick_i,
    input  logic             mode_wr_i,
    input  logic [1:0]       mode_op_i,
    input  logic [1:0]       mode_src_i,
    input  logic             val_wr_i,
    input  logic [CNT_W-1:0] val_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic [1:0] op_q, src_q;
    logic       t_half, t_a, t_b, tick, run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            src_q <= '0;
        end else if (mode_wr_i) begin
            op_q  <= mode_op_i;
            src_q <= mode_src_i;
        end
    end

    assign run = start_i && (op_q == OP_TIMER);

    ivt_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_half (t_half),
        .tick_a    (t_a),
        .tick_b    (t_b)
    );

    ivt_tick_sel u_sel (
        .src       (src_q),
        .half_sel  (half_sel_i),
        .tick_half (t_half),
        .tick_a    (t_a),
        .tick_b    (t_b),
        .slow_tick (slow_tick_i),
        .tick      (tick)
    );

    ivt_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .wr_en   (val_wr_i),
        .wr_data (val_data_i),
        .cnt     (count_o),
        .irq     (irq_o)
    );

    // R5: a non-timer operating field keeps the count still
    p_op_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q != OP_TIMER && !mode_wr_i && !val_wr_i) |=> $stable(count_o));

endmodule

// File: tb/test_ivt_timer.sv
module test_ivt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, half_sel_i = 1'b0;
    logic        mode_wr_i = 1'b0, val_wr_i = 1'b0;
    logic [1:0]  mode_op_i = 2'b00, mode_src_i = 2'b00;
    logic [15:0] val_data_i = '0;
    logic [15:0] count_o;
    logic        irq_o;
    logic        slow_auto = 1'b0, slow_man = 1'b0, slow_pulse = 1'b0;
    logic        slow_tick_i;
    int          slow_ctr = 0;
    int          cyc = 0, n_tests = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    assign slow_tick_i = slow_auto ? slow_pulse : slow_man;

    always @(negedge clk) begin
        slow_ctr   <= (slow_ctr == 4) ? 0 : slow_ctr + 1;
        slow_pulse <= (slow_ctr == 4);
    end

    always @(posedge clk) cyc <= cyc + 1;

    ivt_timer i_ivt_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_sel_i(half_sel_i),
        .slow_tick_i(slow_tick_i), .mode_wr_i(mode_wr_i), .mode_op_i(mode_op_i),
        .mode_src_i(mode_src_i), .val_wr_i(val_wr_i), .val_data_i(val_data_i),
        .count_o(count_o), .irq_o(irq_o)
    );

    // {source field, half_sel, programmed n, expected clocks between interrupts}
    localparam int VEC [8][4] = '{
        '{0, 0,   9,   10},
        '{0, 1,   9,   20},
        '{1, 0,   4,   40},
        '{2, 0,   3,  128},
        '{3, 0,   0,    5},
        '{3, 0,   6,   35},
        '{1, 0, 255, 2048},
        '{0, 0, 999, 1000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] op, input logic [1:0] src);
        mode_op_i = op; mode_src_i = src; mode_wr_i = 1'b1;
        step(1);
        mode_wr_i = 1'b0;
    endtask

    task automatic write_val(input int v);
        val_data_i = 16'(v); val_wr_i = 1'b1;
        step(1);
        val_wr_i = 1'b0;
    endtask

    task automatic pulse_slow();
        slow_man = 1'b1;
        step(1);
        slow_man = 1'b0;
    endtask

    task automatic wait_irq(output int at);
        at = -1;
        for (int i = 0; i < 5000; i++) begin
            step(1);
            if (irq_o) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin : watchdog
        while (cyc < 150000 && !done) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int t1, t2, c0;
        step(3);
        // R1 reset state
        chk(count_o == 16'h0000 && irq_o == 1'b0, "R1 reset", count_o, 0);
        rst_n = 1'b1;
        step(40);
        chk(count_o == 16'h0000 && irq_o == 1'b0, "R1 idle after reset", count_o, 0);

        // R2 R3 R4 period table
        for (int v = 0; v < 8; v++) begin
            start_i = 1'b0;
            slow_auto = 1'b1;
            half_sel_i = VEC[v][1][0];
            set_mode(2'b00, 2'(VEC[v][0]));
            write_val(VEC[v][2]);
            chk(count_o == 16'(VEC[v][2]), "R7 stopped write", count_o, VEC[v][2]);
            start_i = 1'b1;
            wait_irq(t1);
            chk(count_o == 16'(VEC[v][2]), "R3 reload value", count_o, VEC[v][2]);
            wait_irq(t2);
            chk(t1 >= 0 && t2 >= 0 && (t2 - t1) == VEC[v][3], "R2 R4 period", t2 - t1, VEC[v][3]);
            step(1);
            chk(irq_o == 1'b0 || VEC[v][3] == 1, "R3 single pulse", irq_o, 0);
        end

        // R8 running write with fast ticks
        start_i = 1'b0; slow_auto = 1'b0; half_sel_i = 1'b0;
        set_mode(2'b00, 2'b00);
        write_val(100);
        start_i = 1'b1;
        step(10);
        c0 = count_o;
        write_val(5);
        chk(count_o == 16'(c0 - 1), "R8 counter untouched by run write", count_o, c0 - 1);
        wait_irq(t1);
        chk(count_o == 16'd5, "R8 new value at underflow", count_o, 5);
        wait_irq(t2);
        chk((t2 - t1) == 6, "R8 new period", t2 - t1, 6);

        // R6 stop holds
        start_i = 1'b0;
        step(1);
        c0 = count_o;
        step(20);
        chk(count_o == 16'(c0), "R6 hold while stopped", count_o, c0);

        // R5 non-timer operating field holds
        set_mode(2'b01, 2'b00);
        start_i = 1'b1;
        step(1);
        c0 = count_o;
        step(20);
        chk(count_o == 16'(c0), "R5 hold with op field 01", count_o, c0);
        set_mode(2'b00, 2'b00);
        step(3);
        chk(count_o != 16'(c0), "R5 resumes with op 00", count_o, c0 - 3);

        // R7 R8 R9 manual slow ticks
        start_i = 1'b0;
        set_mode(2'b00, 2'b11);
        start_i = 1'b1;
        step(1);
        write_val(7);
        chk(count_o == 16'd7, "R7 armed write loads counter", count_o, 7);
        pulse_slow();
        chk(count_o == 16'd6, "R2 first tick", count_o, 6);
        write_val(3);
        chk(count_o == 16'd6, "R8 run write keeps counter", count_o, 6);
        for (int k = 0; k < 6; k++) pulse_slow();
        chk(count_o == 16'd0 && irq_o == 1'b0, "R2 reach zero", count_o, 0);
        pulse_slow();
        chk(count_o == 16'd3 && irq_o == 1'b1, "R3 underflow reload", count_o, 3);
        step(1);
        chk(irq_o == 1'b0, "R3 one cycle irq", irq_o, 0);
        pulse_slow();
        chk(count_o == 16'd2, "R2 after reload", count_o, 2);

        // R6 restart continues from held value
        start_i = 1'b0;
        step(5);
        start_i = 1'b1;
        step(1);
        pulse_slow();
        chk(count_o == 16'd1, "R6 restart continues", count_o, 1);

        // R9 restart re-arms: write reaches counter again
        start_i = 1'b0;
        step(2);
        start_i = 1'b1;
        step(1);
        write_val(9);
        chk(count_o == 16'd9, "R9 rearmed write loads counter", count_o, 9);
        pulse_slow();
        write_val(4);
        chk(count_o == 16'd8, "R9 after first tick write is reload only", count_o, 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule